// File: doc/BRIEF.md
# Data-Strobe Transmit Serializer

The block turns parallel transmit data from a link layer into a serial data-strobe pair. Once per system clock a word arrives on a byte-wide bus together with a speed code and a valid qualifier. The speed code sets how many low-order lanes of the bus carry data: two, four or eight. The block captures the word and shifts its active lanes out one bit at a time, at 2, 4 or 8 bits per system clock. Each bit is encoded onto a data line and a strobe line.

The whole block runs on a fast bit clock at eight times the system clock. A one-cycle pulse, `sys_stb`, marks the system-clock edge on which a word is captured. At the top rate a bit leaves on every bit-clock cycle. At the two lower rates the serializer advances only on every second or every fourth bit-clock cycle. Pulsing `sys_stb` every eight bit-clock cycles gives an unbroken stream. A receiver recovers the bit timing from the exclusive-or of the two lines.

Top module: `ds_tx_serializer`

## Requirements
- R1: After a synchronous reset, both `ds_data` and `ds_strobe` are 0, and they stay 0 until a word with `tx_valid`=1 has been captured.
- R2: `tx_data`, `speed` and `tx_valid` are captured only at a rising edge where `sys_stb` is 1. Changes to these inputs at any other time have no effect on the word being sent.
- R3: The speed code selects the lanes and the pace. Code 2'b00 sends `tx_data[1:0]`, one bit every 4 bit-clock cycles. Code 2'b01 sends `tx_data[3:0]`, one bit every 2 cycles. Code 2'b10 sends all 8 lanes, one bit every cycle. Code 2'b11 behaves as 2'b00. Lanes above the active ones are ignored.
- R4: Lanes leave in ascending order, with lane 0 first on the wire.
- R5: For each bit, `ds_data` takes the bit value. `ds_strobe` toggles exactly when the bit equals the previous `ds_data` level. Exactly one of the two lines changes per bit, and neither changes at any other time.
- R6: For a word captured at edge E with step s (4, 2 or 1 cycles), bit k is driven onto the outputs at edge E+1+k*s.
- R7: A word captured with `tx_valid`=0 is not sent, and both outputs keep their levels through its slot.
- R8: At the 8-lane rate, with `sys_stb` every 8 cycles, the last bit of one word and the first bit of the next leave on adjacent edges with no gap.
- R9: Once the last bit of a word has left and no new word is captured, both outputs hold their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, eight times the system clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_stb | input | 1 | One-cycle pulse marking the system-clock capture edge |
| speed | input | 2 | Speed code: 00 two lanes, 01 four lanes, 10 eight lanes, 11 as 00 |
| tx_valid | input | 1 | Qualifies the word presented with `sys_stb` |
| tx_data | input | DATA_W | Parallel transmit word; lane 0 is sent first |
| ds_data | output | 1 | Encoded data line |
| ds_strobe | output | 1 | Encoded strobe line |

## Verification
The bound checker watches the output lines on every cycle. It checks that at most one line moves per cycle and that a line moves exactly when the pacing logic fires a bit. It also checks that an unqualified capture leaves the lines quiet, and that at the two lower rates no two adjacent cycles both carry a transition. Bit values, lane order, the exact emission edges, ignored upper lanes and input changes between captures can only be shown by the bench scenarios. The bench decodes the pair with the exclusive-or of the two lines and compares each recovered bit and its edge against a queue filled from the captured words, across all four speed codes, rate changes, back-to-back words and idle gaps.

// File: rtl/ds_tx_pkg.sv
`timescale 1ns/1ps
package ds_tx_pkg;

   typedef enum logic [1:0] {
      SPD_X2  = 2'b00,
      SPD_X4  = 2'b01,
      SPD_X8  = 2'b10,
      SPD_ALT = 2'b11
   } ds_speed_e;

   localparam int unsigned NUM_RATES = 3;

   // Reserved code falls back to the slowest rate.
   function automatic ds_speed_e norm_speed(input logic [1:0] code);
      ds_speed_e s;
      case (code)
         2'b01:   s = SPD_X4;
         2'b10:   s = SPD_X8;
         default: s = SPD_X2;
      endcase
      return s;
   endfunction

   // Index of a rate in the per-rate generate array (0 slowest).
   function automatic logic [1:0] rate_idx(input ds_speed_e s);
      logic [1:0] i;
      case (s)
         SPD_X4:  i = 2'd1;
         SPD_X8:  i = 2'd2;
         default: i = 2'd0;
      endcase
      return i;
   endfunction

endpackage

// File: rtl/ds_phase_gen.sv
`timescale 1ns/1ps
module ds_phase_gen
   import ds_tx_pkg::*;
#(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned PH_W  = $clog2(WORD_W)
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      load,
   input  logic      active,
   input  ds_speed_e spd,
   output logic      ph_last,
   output logic      fire
);

   localparam logic [PH_W-1:0] PH_MAX = PH_W'(WORD_W - 1);

   logic [PH_W-1:0]      ph_q;
   logic [NUM_RATES-1:0] aligned;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= PH_MAX;
      end else if (load) begin
         ph_q <= '0;
      end else if (ph_q != PH_MAX) begin
         ph_q <= ph_q + 1'b1;
      end
   end

   // One alignment test per rate: rate i uses a step of 2^(NUM_RATES-1-i).
   for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
      localparam int unsigned STEP = 1 << (NUM_RATES - 1 - i);
      localparam logic [PH_W-1:0] MASK = PH_W'(STEP - 1);
      assign aligned[i] = (ph_q & MASK) == '0;
   end

   assign ph_last = (ph_q == PH_MAX);
   assign fire    = active & aligned[rate_idx(spd)];

endmodule

// File: rtl/ds_word_latch.sv
`timescale 1ns/1ps
module ds_word_latch
   import ds_tx_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic              vld_in,
   input  logic [1:0]        spd_in,
   input  logic              shift,
   input  logic              ph_last,
   output logic              bit_out,
   output logic              vld_q,
   output ds_speed_e         spd_q
);

   logic [WORD_W-1:0] shreg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= '0;
         vld_q   <= 1'b0;
         spd_q   <= SPD_X2;
      end else if (load) begin
         shreg_q <= din;
         vld_q   <= vld_in;
         spd_q   <= norm_speed(spd_in);
      end else begin
         if (shift) begin
            shreg_q <= shreg_q >> 1;
         end
         if (ph_last) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign bit_out = shreg_q[0];

endmodule

// File: rtl/ds_encoder.sv
`timescale 1ns/1ps
module ds_encoder (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   input  logic bit_in,
   output logic d_out,
   output logic s_out
);

   always_ff @(posedge clk) begin
      if (rst) begin
         d_out <= 1'b0;
         s_out <= 1'b0;
      end else if (fire) begin
         d_out <= bit_in;
         if (bit_in == d_out) begin
            s_out <= ~s_out;
         end
      end
   end

endmodule

// File: rtl/ds_tx_serializer.sv
`timescale 1ns/1ps
module ds_tx_serializer
   import ds_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic              sys_stb,
   input  logic [1:0]        speed,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              ds_data,
   output logic              ds_strobe
);

   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("ds_tx_serializer: DATA_W must be a power of two of at least 4");
   end

   logic      bit_fire;
   logic      ph_last;
   logic      word_vld;
   logic      head_bit;
   ds_speed_e word_spd;

   ds_word_latch #(.WORD_W(DATA_W)) u_latch (
      .clk     (clk_bit),
      .rst     (rst),
      .load    (sys_stb),
      .din     (tx_data),
      .vld_in  (tx_valid),
      .spd_in  (speed),
      .shift   (bit_fire),
      .ph_last (ph_last),
      .bit_out (head_bit),
      .vld_q   (word_vld),
      .spd_q   (word_spd)
   );

   ds_phase_gen #(.WORD_W(DATA_W)) u_phase (
      .clk     (clk_bit),
      .rst     (rst),
      .load    (sys_stb),
      .active  (word_vld),
      .spd     (word_spd),
      .ph_last (ph_last),
      .fire    (bit_fire)
   );

   ds_encoder u_enc (
      .clk    (clk_bit),
      .rst    (rst),
      .fire   (bit_fire),
      .bit_in (head_bit),
      .d_out  (ds_data),
      .s_out  (ds_strobe)
   );

endmodule

// File: rtl/ds_tx_serializer_chk.sv
`timescale 1ns/1ps
module ds_tx_serializer_chk (
   input logic       clk_bit,
   input logic       rst,
   input logic       sys_stb,
   input logic [1:0] speed,
   input logic       tx_valid,
   input logic       ds_data,
   input logic       ds_strobe,
   input logic       bit_fire
);

   logic       prev_d, prev_s;
   logic [1:0] mode_q, mode_prev;
   logic [1:0] chgv;

   always_ff @(posedge clk_bit) begin
      if (rst) begin
         prev_d    <= 1'b0;
         prev_s    <= 1'b0;
         mode_q    <= 2'b00;
         mode_prev <= 2'b00;
      end else begin
         prev_d    <= ds_data;
         prev_s    <= ds_strobe;
         mode_prev <= mode_q;
         if (sys_stb) begin
            mode_q <= speed;
         end
      end
   end

   assign chgv = {ds_data ^ prev_d, ds_strobe ^ prev_s};

   // R5: never both lines in one cycle
   p_single_line_r5: assert property (@(posedge clk_bit) disable iff (rst)
      $countones(chgv) <= 1);

   // R5: a fired bit moves exactly one line
   p_fire_moves_r5: assert property (@(posedge clk_bit) disable iff (rst)
      bit_fire |=> $countones(chgv) == 1);

   // R9: no fire, no movement
   p_quiet_hold_r9: assert property (@(posedge clk_bit) disable iff (rst)
      !bit_fire |=> chgv == 2'b00);

   // R7: unqualified word leaves its first slot quiet
   p_invalid_word_r7: assert property (@(posedge clk_bit) disable iff (rst)
      (sys_stb && !tx_valid) |-> ##2 (chgv == 2'b00));

   // R3: lower rates never emit on adjacent cycles
   p_low_rate_gap_r3: assert property (@(posedge clk_bit) disable iff (rst)
      ((chgv != 2'b00) && (mode_q != 2'b10) && (mode_q == mode_prev)) |=> (chgv == 2'b00));

endmodule

bind ds_tx_serializer ds_tx_serializer_chk u_chk (
   .clk_bit   (clk_bit),
   .rst       (rst),
   .sys_stb   (sys_stb),
   .speed     (speed),
   .tx_valid  (tx_valid),
   .ds_data   (ds_data),
   .ds_strobe (ds_strobe),
   .bit_fire  (bit_fire)
);

// File: tb/test_ds_tx_serializer.sv
`timescale 1ns/1ps
module test_ds_tx_serializer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sys_stb = 1'b0;
   logic [1:0] speed = 2'b00;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       ds_data, ds_strobe;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic mon_en = 1'b0;
   logic pd = 1'b0, ps = 1'b0, ppar = 1'b0;

   logic exp_bit[$];
   int   exp_cyc[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ds_tx_serializer #(.DATA_W(8)) i_ds_tx_serializer (
      .clk_bit   (clk),
      .rst       (rst),
      .sys_stb   (sys_stb),
      .speed     (speed),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .ds_data   (ds_data),
      .ds_strobe (ds_strobe)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Driver: one word per 8 bit-clock cycles; inputs scrambled between captures (R2).
   task automatic send_word(input logic [7:0] d, input logic [1:0] spd, input logic v);
      int lanes, step, e;
      @(negedge clk);
      tx_data = d; speed = spd; tx_valid = v; sys_stb = 1'b1;
      if (v) begin
         lanes = (spd == 2'b10) ? 8 : (spd == 2'b01) ? 4 : 2;
         step  = 8 / lanes;
         e     = cyc + 1;
         for (int k = 0; k < lanes; k++) begin
            exp_bit.push_back(d[k]);
            exp_cyc.push_back(e + 1 + k * step);
         end
      end
      @(negedge clk);
      sys_stb = 1'b0; tx_data = ~d; speed = spd ^ 2'b11; tx_valid = ~v;
      repeat (6) @(negedge clk);
   endtask

   // Monitor: recovers bit timing from data XOR strobe.
   always @(negedge clk) begin
      if (mon_en) begin
         logic par, b;
         int c;
         par = ds_data ^ ds_strobe;
         if ((ds_data !== pd) && (ds_strobe !== ps)) begin
            checks++; errors++;
            $display("FAIL R5: both lines moved at cycle %0d (d=%b s=%b, expected one change)", cyc, ds_data, ds_strobe);
         end else if (par !== ppar) begin
            checks++;
            if (exp_bit.size() == 0) begin
               errors++;
               $display("FAIL R7/R9: unexpected bit %b at cycle %0d, expected no transition", ds_data, cyc);
            end else begin
               b = exp_bit.pop_front();
               c = exp_cyc.pop_front();
               if (ds_data !== b || cyc != c) begin
                  errors++;
                  $display("FAIL R4/R6: bit %b at cycle %0d, expected %b at cycle %0d", ds_data, cyc, b, c);
               end
            end
         end
         pd = ds_data; ps = ds_strobe; ppar = par;
      end
   end

   task automatic check_hold(input int n, input string tag);
      logic d0, s0;
      d0 = ds_data; s0 = ds_strobe;
      repeat (n) @(negedge clk);
      checks++;
      if (ds_data !== d0 || ds_strobe !== s0) begin
         errors++;
         $display("FAIL %s: lines %b%b, expected held %b%b", tag, ds_data, ds_strobe, d0, s0);
      end
   endtask

   task automatic check_drained(input string tag);
      checks++;
      if (exp_bit.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d bits never sent, expected 0", tag, exp_bit.size());
      end
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R1: reset levels
      checks++;
      if (ds_data !== 1'b0 || ds_strobe !== 1'b0) begin
         errors++;
         $display("FAIL R1: lines %b%b after reset, expected 00", ds_data, ds_strobe);
      end
      pd = ds_data; ps = ds_strobe; ppar = ds_data ^ ds_strobe;
      mon_en = 1'b1;
      // R1: quiet with no captured word
      check_hold(10, "R1");

      // R3 R4 R8: 8-lane words back to back
      send_word(8'hA5, 2'b10, 1'b1);
      send_word(8'h3C, 2'b10, 1'b1);
      send_word(8'hFF, 2'b10, 1'b1);
      send_word(8'h00, 2'b10, 1'b1);
      repeat (4) @(negedge clk);
      check_drained("R8");

      // R3: 4-lane rate, upper lanes differ from lower (ignored)
      send_word(8'h5E, 2'b01, 1'b1);
      send_word(8'hFA, 2'b01, 1'b1);
      // R3: 2-lane rate and the reserved code
      send_word(8'hF2, 2'b00, 1'b1);
      send_word(8'h01, 2'b00, 1'b1);
      send_word(8'hE3, 2'b11, 1'b1);
      // R7: unqualified word between valid ones
      send_word(8'h99, 2'b10, 1'b0);
      send_word(8'h6B, 2'b10, 1'b1);
      // rate changes back to back: 8 -> 2 -> 4 -> 8 (R6 timing across switches)
      send_word(8'h81, 2'b10, 1'b1);
      send_word(8'h02, 2'b00, 1'b1);
      send_word(8'h07, 2'b01, 1'b1);
      send_word(8'h4D, 2'b10, 1'b1);
      repeat (4) @(negedge clk);
      check_drained("R6");

      // R9: idle after the last word
      check_hold(20, "R9");

      // R7: an unqualified word alone leaves lines held
      send_word(8'hC3, 2'b10, 1'b0);
      check_hold(6, "R7");
      // R2: strobe-less input changes have no effect
      tx_data = 8'h55; speed = 2'b10; tx_valid = 1'b1;
      check_hold(12, "R2");
      tx_valid = 1'b0;

      send_word(8'h2D, 2'b01, 1'b1);
      repeat (6) @(negedge clk);
      check_drained("R3");

      mon_en = 1'b0;
      summary();
      $finish;
   end

endmodule